// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. The segment is shifted left by four bits, so every segment begins on a 16-byte boundary and covers 64 KB of offsets. The offset is then added to that base. Any carry out of the top address bit is dropped, so addresses wrap within the 1 MB space.

Four 16-bit segment registers are held inside the block: code, stack, data and extra. Each one is loaded through a single synchronous write port. For each access, the caller states what kind of pointer produced the offset. The block uses that kind to pick the segment register implicitly. Instruction fetches use the code segment. Stack-pointer and base-pointer offsets use the stack segment. Ordinary data pointers use the data segment. String destinations use the extra segment. The physical address and the index of the chosen segment are both output combinationally.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment value << 4) + `offset`; for example 348A:4214 gives 38AB4, 5000:FFE0 gives 5FFE0, 1234:0022 gives 12362 and 1234:0012 gives 12352 (hex).
- R2: A sum above FFFFF wraps modulo 2^20: FFFF:0010 gives 00000 and FFFF:FFFF gives 0FFEF.
- R3: Access kind 1 (instruction fetch) selects the code segment, and `seg_sel` reads 0.
- R4: Access kind 2 (stack or base pointer) selects the stack segment, and `seg_sel` reads 1.
- R5: Access kind 0 (general data pointer) selects the data segment, and `seg_sel` reads 2.
- R6: Access kind 3 (string destination) selects the extra segment, and `seg_sel` reads 3.
- R7: After reset all four segment registers read zero, so `phys_addr` equals the zero-extended `offset` for every access kind.
- R8: On a rising clock edge with `wr_en` high, the register indexed by `wr_sel` takes `wr_data`, using the same 0 to 3 index encoding as `seg_sel`. The other three registers keep their values.
- R9: With `wr_en` low, a clock edge changes no segment register.
- R10: `phys_addr` and `seg_sel` follow changes on `acc_kind` and `offset` within the same cycle, with no clock edge needed.
- R11: The low four bits of `phys_addr` always equal the low four bits of `offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; segment writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all segment registers |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Index of the register to write: 0 code, 1 stack, 2 data, 3 extra |
| wr_data | input | 16 | Value to load into the selected segment register |
| acc_kind | input | 2 | Pointer kind: 0 data, 1 fetch, 2 stack/base, 3 string destination |
| offset | input | 16 | Offset supplied by the pointer |
| phys_addr | output | 20 | Physical address |
| seg_sel | output | 2 | Index of the segment register used |

## Verification
The hardest case to reach from the ports is the wrap past FFFFF. It requires a segment value near FFFF and a large offset, both loaded through the write port before the address is read. The bench loads FFFF into a register and applies several offsets to it, including offsets that cross the top. Write isolation is also hard to observe, because the registers have no read port. The bench therefore gives all four registers distinct values. After each write, and after a clock with the enable low, it reads every register back through its own access kind with a zero offset.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int unsigned NUM_SEG = 4;
   localparam int unsigned SEL_W   = 2;

   typedef enum logic [SEL_W-1:0] {
      SEG_CODE  = 2'd0,
      SEG_STACK = 2'd1,
      SEG_DATA  = 2'd2,
      SEG_EXTRA = 2'd3
   } seg_idx_e;

   typedef enum logic [1:0] {
      ACC_DATA   = 2'd0,
      ACC_FETCH  = 2'd1,
      ACC_STACK  = 2'd2,
      ACC_STRDST = 2'd3
   } acc_kind_e;

   function automatic seg_idx_e kind_to_seg(input acc_kind_e k);
      case (k)
         ACC_FETCH:  return SEG_CODE;
         ACC_STACK:  return SEG_STACK;
         ACC_STRDST: return SEG_EXTRA;
         default:    return SEG_DATA;
      endcase
   endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [SEL_W-1:0]                wr_sel,
   input  logic [SEG_W-1:0]                wr_data,
   output logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q
);

   for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_seg
      logic hit;
      assign hit = wr_en && (wr_sel == SEL_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   seg_q[gi] <= '0;
         else if (hit) seg_q[gi] <= wr_data;
      end

      // R8: selected register takes the written value
      a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == SEL_W'(gi)) |=> (seg_q[gi] == $past(wr_data)));

      // R8 / R9: unselected or disabled register keeps its value
      a_r9_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_sel == SEL_W'(gi)) |=> $stable(seg_q[gi]));

      // R7: register is clear when reset is released
      a_r7_zero_after_reset: assert property (@(posedge clk)
         $rose(rst_n) |-> (seg_q[gi] == '0));
   end

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic [1:0]                      acc_kind,
   input  logic [NUM_SEG-1:0][SEG_W-1:0]   seg_q,
   output logic [SEL_W-1:0]                seg_sel,
   output logic [SEG_W-1:0]                seg_val
);

   seg_idx_e idx;

   always_comb begin
      idx     = kind_to_seg(acc_kind_e'(acc_kind));
      seg_sel = idx;
      seg_val = seg_q[idx];
   end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter bit          SPLIT_ADD = 1'b1,
   localparam int unsigned PADDR_W  = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]   seg_val,
   input  logic [OFF_W-1:0]   offset,
   output logic [PADDR_W-1:0] phys_addr
);

   if (SPLIT_ADD) begin : g_split
      // Low SHIFT bits pass straight through; only the upper part needs a carry chain.
      logic [SEG_W-1:0] off_hi;
      logic [SEG_W:0]   hi_sum;
      assign off_hi = SEG_W'(offset[OFF_W-1:SHIFT]);
      assign hi_sum = {1'b0, seg_val} + {1'b0, off_hi};
      assign phys_addr = {hi_sum[SEG_W-1:0], offset[SHIFT-1:0]};
   end else begin : g_full
      logic [PADDR_W:0] sum;
      assign sum = {1'b0, seg_val, {SHIFT{1'b0}}} + (PADDR_W+1)'(offset);
      assign phys_addr = sum[PADDR_W-1:0];
   end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_addr_pkg::*;
#(
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned SHIFT     = 4,
   parameter bit          SPLIT_ADD = 1'b1,
   localparam int unsigned PADDR_W  = SEG_W + SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [SEG_W-1:0]   wr_data,
   input  logic [1:0]         acc_kind,
   input  logic [OFF_W-1:0]   offset,
   output logic [PADDR_W-1:0] phys_addr,
   output logic [1:0]         seg_sel
);

   if (SHIFT < 1 || OFF_W <= SHIFT || OFF_W > PADDR_W) begin : g_bad_widths
      $error("seg_addr_gen: need 1 <= SHIFT < OFF_W <= SEG_W + SHIFT");
   end
   if (SEL_W != $clog2(NUM_SEG)) begin : g_bad_sel
      $error("seg_addr_gen: select width does not match segment count");
   end

   logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
   logic [SEG_W-1:0]              seg_val;

   seg_regfile #(.SEG_W(SEG_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .seg_q   (seg_q)
   );

   seg_select #(.SEG_W(SEG_W)) sel_i (
      .acc_kind (acc_kind),
      .seg_q    (seg_q),
      .seg_sel  (seg_sel),
      .seg_val  (seg_val)
   );

   seg_adder #(
      .SEG_W     (SEG_W),
      .OFF_W     (OFF_W),
      .SHIFT     (SHIFT),
      .SPLIT_ADD (SPLIT_ADD)
   ) add_i (
      .seg_val   (seg_val),
      .offset    (offset),
      .phys_addr (phys_addr)
   );

   // R3..R6: implicit segment choice at the ports
   a_r3_fetch_code: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd1) |-> (seg_sel == 2'd0));
   a_r4_stack_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd2) |-> (seg_sel == 2'd1));
   a_r5_data_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd0) |-> (seg_sel == 2'd2));
   a_r6_extra_seg: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == 2'd3) |-> (seg_sel == 2'd3));

   // R11: base is 16-byte aligned, so low address bits come from the offset
   a_r11_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[SHIFT-1:0] == offset[SHIFT-1:0]);

   // R1: with a zero offset the address is the aligned base of the chosen register
   a_r1_zero_offset_base: assert property (@(posedge clk) disable iff (!rst_n)
      (offset == '0) |-> (phys_addr == {seg_q[seg_sel], {SHIFT{1'b0}}}));

endmodule

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  acc_kind = '0;
   logic [15:0] offset = '0;
   logic [19:0] phys_addr;
   logic [1:0]  seg_sel;

   int checks = 0;
   int errors = 0;

   // expected register contents indexed by segment index 0 code,1 stack,2 data,3 extra
   logic [15:0] model_seg [4];

   always #5 clk = ~clk;

   seg_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .acc_kind(acc_kind), .offset(offset), .phys_addr(phys_addr), .seg_sel(seg_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] kind_seg(input logic [1:0] k);
      case (k)
         2'd1: return 2'd0;
         2'd2: return 2'd1;
         2'd3: return 2'd3;
         default: return 2'd2;
      endcase
   endfunction

   function automatic logic [19:0] ref_addr(input logic [15:0] s, input logic [15:0] o);
      logic [20:0] t;
      t = {1'b0, s, 4'h0} + {5'h0, o};
      return t[19:0];
   endfunction

   function automatic logic [1:0] kind_for_seg(input logic [1:0] s);
      case (s)
         2'd0: return 2'd1;
         2'd1: return 2'd2;
         2'd3: return 2'd3;
         default: return 2'd0;
      endcase
   endfunction

   task automatic set_seg(input logic [1:0] sel, input logic [15:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
      model_seg[sel] = val;
   endtask

   task automatic probe(input logic [1:0] k, input logic [15:0] o);
      acc_kind = k; offset = o;
      #1;
   endtask

   task automatic check_all_regs(input string req);
      for (int s = 0; s < 4; s++) begin
         probe(kind_for_seg(2'(s)), 16'h0000);
         chk(req, {12'h0, phys_addr}, {12'h0, model_seg[s], 4'h0});
      end
   endtask

   task automatic t_reset;
      for (int k = 0; k < 4; k++) begin
         probe(2'(k), 16'hA5C3);
         chk("R7 reset zero segment", {12'h0, phys_addr}, 32'h0000A5C3);
      end
   endtask

   task automatic t_kinds;
      set_seg(2'd0, 16'h1000);
      set_seg(2'd1, 16'h2000);
      set_seg(2'd2, 16'h3000);
      set_seg(2'd3, 16'h4000);
      probe(2'd1, 16'h0001);
      chk("R3 fetch seg_sel", {30'h0, seg_sel}, 32'd0);
      chk("R3 fetch addr", {12'h0, phys_addr}, 32'h10001);
      probe(2'd2, 16'h0002);
      chk("R4 stack seg_sel", {30'h0, seg_sel}, 32'd1);
      chk("R4 stack addr", {12'h0, phys_addr}, 32'h20002);
      probe(2'd0, 16'h0003);
      chk("R5 data seg_sel", {30'h0, seg_sel}, 32'd2);
      chk("R5 data addr", {12'h0, phys_addr}, 32'h30003);
      probe(2'd3, 16'h0004);
      chk("R6 strdst seg_sel", {30'h0, seg_sel}, 32'd3);
      chk("R6 strdst addr", {12'h0, phys_addr}, 32'h40004);
   endtask

   task automatic t_examples;
      set_seg(2'd0, 16'h348A);
      probe(2'd1, 16'h4214);
      chk("R1 348A:4214", {12'h0, phys_addr}, 32'h38AB4);
      set_seg(2'd1, 16'h5000);
      probe(2'd2, 16'hFFE0);
      chk("R1 5000:FFE0", {12'h0, phys_addr}, 32'h5FFE0);
      set_seg(2'd2, 16'h1234);
      probe(2'd0, 16'h0022);
      chk("R1 1234:0022", {12'h0, phys_addr}, 32'h12362);
      set_seg(2'd0, 16'h1234);
      probe(2'd1, 16'h0012);
      chk("R1 fetch 1234:0012", {12'h0, phys_addr}, 32'h12352);
   endtask

   task automatic t_wrap;
      set_seg(2'd3, 16'hFFFF);
      probe(2'd3, 16'h0010);
      chk("R2 wrap FFFF:0010", {12'h0, phys_addr}, 32'h00000);
      probe(2'd3, 16'hFFFF);
      chk("R2 wrap FFFF:FFFF", {12'h0, phys_addr}, 32'h0FFEF);
      probe(2'd3, 16'h000F);
      chk("R2 top no wrap FFFF:000F", {12'h0, phys_addr}, 32'hFFFFF);
   endtask

   task automatic t_isolation;
      set_seg(2'd0, 16'h0A0A);
      set_seg(2'd1, 16'h1B1B);
      set_seg(2'd2, 16'h2C2C);
      set_seg(2'd3, 16'h3D3D);
      check_all_regs("R8 distinct loads");
      set_seg(2'd2, 16'h7777);
      check_all_regs("R8 single write isolation");
   endtask

   task automatic t_no_write;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'd1; wr_data = 16'hDEAD;
      @(negedge clk);
      @(negedge clk);
      check_all_regs("R9 no write when disabled");
   endtask

   task automatic t_comb;
      @(negedge clk);
      probe(2'd1, 16'h0000);
      chk("R10 comb fetch", {12'h0, phys_addr}, {12'h0, ref_addr(model_seg[0], 16'h0000)});
      probe(2'd2, 16'h0123);
      chk("R10 comb kind change same cycle", {12'h0, phys_addr},
          {12'h0, ref_addr(model_seg[1], 16'h0123)});
      probe(2'd2, 16'h0456);
      chk("R10 comb offset change same cycle", {12'h0, phys_addr},
          {12'h0, ref_addr(model_seg[1], 16'h0456)});
   endtask

   task automatic t_random;
      for (int n = 0; n < 200; n++) begin
         logic [1:0]  s;
         logic [15:0] v;
         logic [1:0]  k;
         logic [15:0] o;
         s = 2'($urandom); v = 16'($urandom);
         set_seg(s, v);
         k = 2'($urandom); o = 16'($urandom);
         probe(k, o);
         chk("R1 random address", {12'h0, phys_addr},
             {12'h0, ref_addr(model_seg[kind_seg(k)], o)});
         chk("R11 random low bits", {28'h0, phys_addr[3:0]}, {28'h0, o[3:0]});
         chk("R3-R6 random seg_sel", {30'h0, seg_sel}, {30'h0, kind_seg(k)});
      end
   endtask

   initial begin
      for (int i = 0; i < 4; i++) model_seg[i] = 16'h0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_kinds;
      t_examples;
      t_wrap;
      t_isolation;
      t_no_write;
      t_comb;
      t_random;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule